// File: doc/BRIEF.md
# SPI hold pause controller

This block sits between the serial pins of an SPI slave and its protocol engine and implements the pause function of the hold input. It brings chip select, serial clock and the active-low hold input into the system clock domain through one shared synchronizer. From them it derives rising and falling serial-clock edge strobes for the engine, a pause level that freezes the engine's shift and count logic, and an output-enable for the serial data output. The engine keeps its bit counters, shift registers and command state untouched while paused. Because the strobes are gated, the next edge it sees is the one that follows the paused bit, so the sequence carries on without a restart.

The pause is entered and left only while the serial clock is low. A hold change that arrives while the clock is high waits for the next falling clock edge, and that falling edge is absorbed by the transition and never reaches the engine. The data output is released to high impedance as soon as hold goes low, before the pause itself takes effect. If chip select is raised while paused, the pause is dropped and a one-cycle abort strobe tells the engine to discard the sequence without committing any write.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, and while chip select is high, pause_o, so_en_o, abort_o and both edge strobes are 0.
- R2: With chip select low, hold low while the serial clock is low sets pause_o. No rising or falling edge strobe is issued while pause_o is 1, so the engine sees no clock or data activity.
- R3: Hold going low while the serial clock is high does not set pause_o at once. pause_o is set at the next falling clock edge if hold is still low, and that falling edge gives no strobe.
- R4: so_en_o is 1 only when chip select is low, hold is high and pause_o is 0. In particular it is 0 during a pending, not yet effective pause.
- R5: While paused, hold going high with the serial clock low clears pause_o, and edge strobes resume from the next clock edge.
- R6: While paused, hold going high with the serial clock high keeps pause_o set. The pause ends at the next falling clock edge if hold is still high there, and that edge gives no strobe. If hold goes low again first, the pause stays in force.
- R7: If hold returns high before the falling edge that would start a pending pause, no pause occurs and that falling edge is strobed normally.
- R8: Chip select rising while pause_o is 1 gives exactly one abort_o pulse and clears pause_o.
- R9: Outside a pause and with chip select low, every serial clock rise gives one sck_rise_en_o pulse and every fall gives one sck_fall_en_o pulse. With chip select high, no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock pin |
| cs_ni | input | 1 | Chip select pin, active low |
| hold_ni | input | 1 | Hold pin, active low |
| pause_o | output | 1 | Freeze engine state while 1 |
| sck_rise_en_o | output | 1 | One-cycle strobe: deliver a serial clock rise to the engine |
| sck_fall_en_o | output | 1 | One-cycle strobe: deliver a serial clock fall to the engine |
| so_en_o | output | 1 | Serial data output may drive when 1, high impedance when 0 |
| abort_o | output | 1 | One-cycle strobe: sequence dropped by deselect during a pause |

## Verification
The embedded properties check on every cycle that no edge strobe appears while paused or deselected, and that the output is never enabled during a pause. They also check that the pause only starts or ends in a cycle following a low serial clock, and that an abort always clears the pause. The deferral rules need the bench scenarios, because they depend on the order of input events. These rules are a pending entry cancelled by an early release, a pending exit cancelled by hold falling again, and the absorbed falling edge. The bench also shows that the edge strobe count matches the clock toggles exactly.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [1:0] {
    ST_RUN        = 2'd0,
    ST_ENTER_WAIT = 2'd1,
    ST_PAUSED     = 2'd2,
    ST_EXIT_WAIT  = 2'd3
  } hold_state_e;

  localparam int unsigned PIN_W    = 3;
  localparam int unsigned PIN_SCK  = 0;
  localparam int unsigned PIN_HOLD = 1;
  localparam int unsigned PIN_CS   = 2;
  localparam logic [PIN_W-1:0] PIN_RST = 3'b110;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s_i;
  end

  assign rise_o = sck_s_i & ~sck_q;
  assign fall_o = ~sck_s_i & sck_q;
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  input  logic cs_n_s_i,
  input  logic hold_n_s_i,
  input  logic sck_rise_i,
  input  logic sck_fall_i,
  output logic pause_o,
  output logic rise_en_o,
  output logic fall_en_o,
  output logic so_en_o,
  output logic abort_o
);
  hold_state_e state_q, state_d;
  logic        paused;

  assign paused = (state_q == ST_PAUSED) || (state_q == ST_EXIT_WAIT);

  always_comb begin
    state_d = state_q;
    if (cs_n_s_i) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN:
          if (!hold_n_s_i) state_d = sck_s_i ? ST_ENTER_WAIT : ST_PAUSED;
        ST_ENTER_WAIT:
          if (sck_fall_i)      state_d = hold_n_s_i ? ST_RUN : ST_PAUSED;
          else if (hold_n_s_i) state_d = ST_RUN;
        ST_PAUSED:
          if (hold_n_s_i) state_d = sck_s_i ? ST_EXIT_WAIT : ST_RUN;
        ST_EXIT_WAIT:
          if (sck_fall_i)       state_d = hold_n_s_i ? ST_RUN : ST_PAUSED;
          else if (!hold_n_s_i) state_d = ST_PAUSED;
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  // the falling edge that completes a pending pause is absorbed
  assign rise_en_o = sck_rise_i & ~cs_n_s_i & (state_q == ST_RUN);
  assign fall_en_o = sck_fall_i & ~cs_n_s_i &
                     ((state_q == ST_RUN) || (state_q == ST_ENTER_WAIT && hold_n_s_i));
  assign pause_o   = paused;
  assign so_en_o   = ~cs_n_s_i & hold_n_s_i & ~paused;
  assign abort_o   = cs_n_s_i & paused;

  a_r2_no_edges_paused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |-> !(rise_en_o || fall_en_o));
  a_r4_so_off_paused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |-> !so_en_o);
  a_r3_enter_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pause_o) |-> $past(!sck_s_i));
  a_r6_exit_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pause_o) |-> $past(!sck_s_i || cs_n_s_i));
  a_r8_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !pause_o);
  a_r9_edges_need_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_en_o || fall_en_o) |-> !cs_n_s_i);
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic hold_ni,
  output logic pause_o,
  output logic sck_rise_en_o,
  output logic sck_fall_en_o,
  output logic so_en_o,
  output logic abort_o
);
  logic [PIN_W-1:0] pins_raw, pins_s;
  logic             sck_rise, sck_fall;

  // one chain for all pins keeps hold and clock ordering intact
  assign pins_raw[PIN_SCK]  = sck_i;
  assign pins_raw[PIN_HOLD] = hold_ni;
  assign pins_raw[PIN_CS]   = cs_ni;

  spi_hold_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  spi_hold_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_s_i(pins_s[PIN_SCK]),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  spi_hold_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_s_i   (pins_s[PIN_SCK]),
    .cs_n_s_i  (pins_s[PIN_CS]),
    .hold_n_s_i(pins_s[PIN_HOLD]),
    .sck_rise_i(sck_rise),
    .sck_fall_i(sck_fall),
    .pause_o   (pause_o),
    .rise_en_o (sck_rise_en_o),
    .fall_en_o (sck_fall_en_o),
    .so_en_o   (so_en_o),
    .abort_o   (abort_o)
  );
endmodule

// File: tb/spi_hold_ctrl_test.sv
module spi_hold_ctrl_test;
  localparam int M_RUN = 0, M_ENTER = 1, M_PAUSED = 2, M_EXIT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1;
  logic pause, rise_en, fall_en, so_en, abort_p;

  int checks = 0, errors = 0;
  int n_rise = 0, n_fall = 0, n_abort = 0;
  int e_rise = 0, e_fall = 0, e_abort = 0;
  int m_state = M_RUN;

  always #5 clk = ~clk;

  spi_hold_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .hold_ni(hold_n),
    .pause_o(pause), .sck_rise_en_o(rise_en), .sck_fall_en_o(fall_en),
    .so_en_o(so_en), .abort_o(abort_p)
  );

  always @(negedge clk) begin
    if (rise_en) n_rise++;
    if (fall_en) n_fall++;
    if (abort_p) n_abort++;
  end

  function automatic int m_next(int s, bit sk, bit csn, bit hn, bit fell);
    if (csn) return M_RUN;
    case (s)
      M_RUN:    return hn ? M_RUN : (sk ? M_ENTER : M_PAUSED);
      M_ENTER:  return fell ? (hn ? M_RUN : M_PAUSED) : (hn ? M_RUN : M_ENTER);
      M_PAUSED: return hn ? (sk ? M_EXIT : M_RUN) : M_PAUSED;
      default:  return fell ? (hn ? M_RUN : M_PAUSED) : (hn ? M_EXIT : M_PAUSED);
    endcase
  endfunction

  function automatic bit m_paused(int s);
    return (s == M_PAUSED) || (s == M_EXIT);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit nsck, bit ncs, bit nhold);
    bit fell, rose;
    fell = sck & ~nsck;
    rose = ~sck & nsck;
    if (rose && !ncs && m_state == M_RUN) e_rise++;
    if (fell && !ncs && (m_state == M_RUN || (m_state == M_ENTER && nhold))) e_fall++;
    if (ncs && m_paused(m_state)) e_abort++;
    m_state = m_next(m_state, nsck, ncs, nhold, fell);
    for (int i = 0; i < 2; i++) m_state = m_next(m_state, nsck, ncs, nhold, 1'b0);
    @(negedge clk);
    sck = nsck; cs_n = ncs; hold_n = nhold;
    repeat (6) @(negedge clk);
    #1;
    check(tag, "pause_o", int'(pause), int'(m_paused(m_state)));
    check(tag, "so_en_o", int'(so_en), int'(!ncs && nhold && !m_paused(m_state)));
    check(tag, "rise strobes", n_rise, e_rise);
    check(tag, "fall strobes", n_fall, e_fall);
    check(tag, "abort strobes", n_abort, e_abort);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1", "pause_o", int'(pause), 0);
    check("R1", "so_en_o", int'(so_en), 0);
    check("R1", "abort_o", int'(abort_p), 0);
    rst_n = 1'b1;
    step("R1", 1'b1, 1'b1, 1'b1);
    step("R1", 1'b0, 1'b1, 1'b0);
    step("R1", 1'b0, 1'b1, 1'b1);
    step("R9", 1'b0, 1'b0, 1'b1);
    step("R9", 1'b1, 1'b0, 1'b1);
    step("R9", 1'b0, 1'b0, 1'b1);
    // R2 / R5: pause with clock low, resume with clock low
    step("R2", 1'b0, 1'b0, 1'b0);
    step("R2", 1'b1, 1'b0, 1'b0);
    step("R2", 1'b0, 1'b0, 1'b0);
    step("R5", 1'b0, 1'b0, 1'b1);
    step("R5", 1'b1, 1'b0, 1'b1);
    // R3 / R4: pending entry while clock high
    step("R4", 1'b1, 1'b0, 1'b0);
    step("R3", 1'b0, 1'b0, 1'b0);
    // R6: release while clock high, cancelled, then completed
    step("R6", 1'b1, 1'b0, 1'b0);
    step("R6", 1'b1, 1'b0, 1'b1);
    step("R6", 1'b1, 1'b0, 1'b0);
    step("R6", 1'b1, 1'b0, 1'b1);
    step("R6", 1'b0, 1'b0, 1'b1);
    step("R6", 1'b1, 1'b0, 1'b1);
    // R7: pending entry cancelled before the falling edge
    step("R7", 1'b1, 1'b0, 1'b0);
    step("R7", 1'b1, 1'b0, 1'b1);
    step("R7", 1'b0, 1'b0, 1'b1);
    // R8: deselect while paused
    step("R8", 1'b0, 1'b0, 1'b0);
    step("R8", 1'b0, 1'b1, 1'b0);
    step("R8", 1'b0, 1'b0, 1'b0);
    step("R8", 1'b1, 1'b0, 1'b1);
    step("R8", 1'b1, 1'b1, 1'b1);
    step("R8", 1'b1, 1'b0, 1'b1);
    // R9 random mix
    for (int k = 0; k < 400; k++) begin
      int r;
      bit a, b, c;
      r = int'($urandom % 16);
      a = sck; b = cs_n; c = hold_n;
      if (r < 7)       a = ~a;
      else if (r < 12) c = ~c;
      else if (r < 14) begin a = ~a; c = ~c; end
      else             b = ~b;
      step("R9", a, b, c);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule